// File: doc/BRIEF.md
# Pixel Uniformity Statistics Unit

This block watches a stream of digitised pixel samples from one sensor line and condenses the line into a few uniformity figures. A sample counts toward the line only in a cycle where its valid qualifier is high. Each counted sample also carries a flag that marks it as odd or even, so that neighbouring pixels can be compared in pairs. All figures are gathered in a single pass. The whole line is never stored: the unit keeps a running sum, the smallest and largest sample seen, and a running sum of absolute odd-to-even differences.

When the end-of-line strobe arrives, the unit checks that exactly the configured number of valid samples was seen. It then derives the results with one shared sequential divider. These results are the integer mean level and the largest absolute distance of any sample from that mean. A mode bit, sampled with the strobe, selects how the line is read. A dark line yields only the offset figures. An illuminated line also yields the deviation as a percentage of the mean and the odd/even imbalance as a percentage. All results appear together in the cycle of a one-cycle completion pulse. A line with the wrong count raises an error flag and leaves the previous results in place. Accumulation of the next line starts at once, so the next line can stream in while the arithmetic for the previous one runs.

Top module: `pixel_uniformity_stats`

## Requirements
- R1: While reset is held, and right after it, `done`, `lineErr`, `darkResult` and every result output are zero.
- R2: `meanOut` is floor(S / LINE_PIXELS), where S is the sum of the samples taken in cycles with `pixValid` high. Samples offered with `pixValid` low have no effect.
- R3: `maxDevOut` is the larger of (largest sample − `meanOut`) and (`meanOut` − smallest sample) over the line's valid samples.
- R4: For an illuminated line (`darkMode` = 0), `devPctOut` is floor(`maxDevOut` × 100 / `meanOut`). It is 0 when `meanOut` is 0.
- R5: For an illuminated line, `imbPctOut` is floor(200 × P / S) and never exceeds 200. P is the sum of |odd − even| over each valid sample flagged odd (`pixOdd` = 1) and the next valid sample flagged even (`pixOdd` = 0). `imbPctOut` is 0 when S is 0. An even sample with no odd sample waiting adds nothing. A second odd sample replaces the waiting one.
- R6: `darkMode` is sampled in the end-of-line cycle, with 1 meaning dark. For a dark line, `darkResult` = 1 and both percentage outputs read 0, while `meanOut` and `maxDevOut` follow R2 and R3.
- R7: A line whose valid count differs from LINE_PIXELS, whether short or long, makes `done` pulse with `lineErr` = 1 and leaves every result output unchanged. The next good line clears `lineErr`.
- R8: `done` is high for exactly one cycle per completed line. The result outputs change only on the edge that raises `done`.
- R9: A valid sample presented in the same cycle as `lineEnd` belongs to the next line, not to the line being closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pixValid | input | 1 | Sample qualifier |
| pixOdd | input | 1 | 1 = odd-position sample, 0 = even |
| pixData | input | SAMPLE_W | Unsigned pixel sample |
| lineEnd | input | 1 | End-of-line strobe |
| darkMode | input | 1 | 1 = dark line, 0 = illuminated |
| meanOut | output | SAMPLE_W | Integer mean level |
| maxDevOut | output | SAMPLE_W | Largest absolute deviation from the mean |
| devPctOut | output | SAMPLE_W+7 | Deviation percentage |
| imbPctOut | output | 8 | Odd/even imbalance percentage |
| darkResult | output | 1 | Results belong to a dark line |
| lineErr | output | 1 | Last line had a wrong valid count |
| done | output | 1 | One-cycle completion pulse |

## Verification
A wrong accumulator bit shows up at the next `done` pulse as a mean, deviation or imbalance that differs from the bench's value. The lag is at most one line plus the divide latency. A control fault that publishes on an error line, or skips the percentage steps, is caught in that same pulse by comparing against the values held from the line before. The bench uses a carried sample on the closing strobe, dropped invalid cycles, and all-zero and full-scale lines. Together these expose mistakes in the clearing order, the qualifier and the divide-by-zero guard within a single line.

// File: rtl/ustat_pkg.sv
package ustat_pkg;
  typedef enum logic [1:0] {
    DIV_MEAN = 2'd0,
    DIV_DEV  = 2'd1,
    DIV_IMB  = 2'd2
  } divSel_e;

  typedef struct packed {
    logic    snap;
    logic    divStart;
    divSel_e divSel;
    logic    loadMean;
    logic    loadDev;
    logic    loadImb;
    logic    publish;
    logic    flagErr;
  } ctrlStrobes_t;
endpackage

// File: rtl/ustat_divider.sv
module ustat_divider #(
  parameter int NUM_W = 35,
  parameter int DEN_W = 27
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NUM_W-1:0] numer,
  input  logic [DEN_W-1:0] denom,
  output logic             divDone,
  output logic [NUM_W-1:0] quotient
);
  localparam int CW = $clog2(NUM_W + 1);

  logic [DEN_W-1:0] remR, denR;
  logic [NUM_W-1:0] quoR;
  logic [CW-1:0]    cnt;
  logic             denZero, doneR;
  logic [DEN_W:0]   remShift, diff;
  logic             fits;

  always_comb begin
    remShift = {remR, quoR[NUM_W-1]};
    diff     = remShift - {1'b0, denR};
    fits     = remShift >= {1'b0, denR};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remR <= '0; quoR <= '0; denR <= '0; cnt <= '0;
      denZero <= 1'b0; doneR <= 1'b0;
    end else if (start) begin
      remR    <= '0;
      quoR    <= numer;
      denR    <= denom;
      denZero <= (denom == '0);
      cnt     <= CW'(NUM_W);
      doneR   <= 1'b0;
    end else if (cnt != '0) begin
      cnt   <= cnt - 1'b1;
      remR  <= fits ? diff[DEN_W-1:0] : remShift[DEN_W-1:0];
      quoR  <= {quoR[NUM_W-2:0], fits};
      doneR <= (cnt == CW'(1));
    end else begin
      doneR <= 1'b0;
    end
  end

  assign divDone  = doneR;
  assign quotient = denZero ? '0 : quoR;
endmodule

// File: rtl/ustat_ctrl.sv
module ustat_ctrl
  import ustat_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         lineEnd,
  input  logic         cntOk,
  input  logic         divDone,
  input  logic         frozenDark,
  output ctrlStrobes_t strobes,
  output logic         done,
  output logic         lineErr
);
  typedef enum logic [2:0] {
    S_IDLE, S_MEAN, S_DEVGO, S_DEV, S_IMB, S_PUB
  } state_e;

  state_e state, stateNext;

  always_comb begin
    strobes   = '0;
    stateNext = state;
    case (state)
      S_IDLE: if (lineEnd) begin
        if (cntOk) begin
          strobes.snap     = 1'b1;
          strobes.divStart = 1'b1;
          strobes.divSel   = DIV_MEAN;
          stateNext        = S_MEAN;
        end else begin
          strobes.flagErr = 1'b1;
        end
      end
      S_MEAN: if (divDone) begin
        strobes.loadMean = 1'b1;
        stateNext        = S_DEVGO;
      end
      S_DEVGO: begin
        if (frozenDark) begin
          stateNext = S_PUB;
        end else begin
          strobes.divStart = 1'b1;
          strobes.divSel   = DIV_DEV;
          stateNext        = S_DEV;
        end
      end
      S_DEV: if (divDone) begin
        strobes.loadDev  = 1'b1;
        strobes.divStart = 1'b1;
        strobes.divSel   = DIV_IMB;
        stateNext        = S_IMB;
      end
      S_IMB: if (divDone) begin
        strobes.loadImb = 1'b1;
        stateNext       = S_PUB;
      end
      S_PUB: begin
        strobes.publish = 1'b1;
        stateNext       = S_IDLE;
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      done    <= 1'b0;
      lineErr <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= strobes.publish | strobes.flagErr;
      if (strobes.flagErr)      lineErr <= 1'b1;
      else if (strobes.publish) lineErr <= 1'b0;
    end
  end
endmodule

// File: rtl/ustat_datapath.sv
module ustat_datapath
  import ustat_pkg::*;
#(
  parameter int SAMPLE_W    = 12,
  parameter int LINE_PIXELS = 21360
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pixValid,
  input  logic                pixOdd,
  input  logic [SAMPLE_W-1:0] pixData,
  input  logic                lineEnd,
  input  logic                darkMode,
  input  ctrlStrobes_t        strobes,
  output logic                cntOk,
  output logic                divDone,
  output logic                frozenDark,
  output logic [SAMPLE_W-1:0] meanOut,
  output logic [SAMPLE_W-1:0] maxDevOut,
  output logic [SAMPLE_W+6:0] devPctOut,
  output logic [7:0]          imbPctOut,
  output logic                darkResult
);
  localparam int CNT_W = $clog2(LINE_PIXELS + 2);
  localparam int SUM_W = SAMPLE_W + $clog2(LINE_PIXELS + 1);
  localparam int NUM_W = SUM_W + 8;
  localparam int PCT_W = SAMPLE_W + 7;
  localparam logic [CNT_W-1:0] CNT_SAT = '1;

  // running accumulators
  logic [CNT_W-1:0]    cntAcc, cntBase;
  logic [SUM_W-1:0]    sumAcc, sumBase, pairAcc, pairBase;
  logic [SAMPLE_W-1:0] minAcc, minBase, maxAcc, maxBase, pendVal, pendBase;
  logic                pendOk, pendOkBase;
  logic [SAMPLE_W-1:0] absDiff;

  // frozen line values and intermediate results
  logic [SUM_W-1:0]    frozenSum, frozenPair;
  logic [SAMPLE_W-1:0] frozenMin, frozenMax, meanReg, maxDev, hiDiff, loDiff;
  logic [PCT_W-1:0]    devReg;
  logic [7:0]          imbReg;

  // divider operands
  logic [NUM_W-1:0]    divNum, quotient;
  logic [SUM_W-1:0]    divDen;

  always_comb begin
    cntBase    = lineEnd ? '0 : cntAcc;
    sumBase    = lineEnd ? '0 : sumAcc;
    pairBase   = lineEnd ? '0 : pairAcc;
    minBase    = lineEnd ? '1 : minAcc;
    maxBase    = lineEnd ? '0 : maxAcc;
    pendBase   = pendVal;
    pendOkBase = lineEnd ? 1'b0 : pendOk;
    absDiff    = (pendBase > pixData) ? pendBase - pixData : pixData - pendBase;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cntAcc <= '0; sumAcc <= '0; pairAcc <= '0;
      minAcc <= '1; maxAcc <= '0; pendVal <= '0; pendOk <= 1'b0;
    end else begin
      cntAcc  <= cntBase;
      sumAcc  <= sumBase;
      pairAcc <= pairBase;
      minAcc  <= minBase;
      maxAcc  <= maxBase;
      pendOk  <= pendOkBase;
      if (pixValid) begin
        if (cntBase != CNT_SAT) cntAcc <= cntBase + 1'b1;
        sumAcc <= sumBase + SUM_W'(pixData);
        if (pixData < minBase) minAcc <= pixData;
        if (pixData > maxBase) maxAcc <= pixData;
        if (pixOdd) begin
          pendVal <= pixData;
          pendOk  <= 1'b1;
        end else if (pendOkBase) begin
          pairAcc <= pairBase + SUM_W'(absDiff);
          pendOk  <= 1'b0;
        end
      end
    end
  end

  assign cntOk = (cntAcc == CNT_W'(LINE_PIXELS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frozenSum <= '0; frozenPair <= '0; frozenMin <= '0; frozenMax <= '0;
      frozenDark <= 1'b0;
    end else if (strobes.snap) begin
      frozenSum  <= sumAcc;
      frozenPair <= pairAcc;
      frozenMin  <= minAcc;
      frozenMax  <= maxAcc;
      frozenDark <= darkMode;
    end
  end

  always_comb begin
    hiDiff = (frozenMax > meanReg) ? frozenMax - meanReg : '0;
    loDiff = (meanReg > frozenMin) ? meanReg - frozenMin : '0;
    maxDev = (hiDiff > loDiff) ? hiDiff : loDiff;
  end

  always_comb begin
    case (strobes.divSel)
      DIV_DEV: begin
        divNum = NUM_W'(maxDev) * NUM_W'(100);
        divDen = SUM_W'(meanReg);
      end
      DIV_IMB: begin
        divNum = NUM_W'(frozenPair) * NUM_W'(200);
        divDen = frozenSum;
      end
      default: begin
        divNum = NUM_W'(sumAcc);
        divDen = SUM_W'(LINE_PIXELS);
      end
    endcase
  end

  ustat_divider #(.NUM_W(NUM_W), .DEN_W(SUM_W)) div_i (
    .clk(clk), .rst_n(rst_n), .start(strobes.divStart),
    .numer(divNum), .denom(divDen), .divDone(divDone), .quotient(quotient)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meanReg <= '0; devReg <= '0; imbReg <= '0;
      meanOut <= '0; maxDevOut <= '0; devPctOut <= '0; imbPctOut <= '0;
      darkResult <= 1'b0;
    end else begin
      if (strobes.loadMean) meanReg <= quotient[SAMPLE_W-1:0];
      if (strobes.loadDev)  devReg  <= quotient[PCT_W-1:0];
      if (strobes.loadImb)  imbReg  <= quotient[7:0];
      if (strobes.publish) begin
        meanOut    <= meanReg;
        maxDevOut  <= maxDev;
        devPctOut  <= frozenDark ? '0 : devReg;
        imbPctOut  <= frozenDark ? '0 : imbReg;
        darkResult <= frozenDark;
      end
    end
  end
endmodule

// File: rtl/pixel_uniformity_stats.sv
module pixel_uniformity_stats
  import ustat_pkg::*;
#(
  parameter int SAMPLE_W    = 12,
  parameter int LINE_PIXELS = 21360
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pixValid,
  input  logic                pixOdd,
  input  logic [SAMPLE_W-1:0] pixData,
  input  logic                lineEnd,
  input  logic                darkMode,
  output logic [SAMPLE_W-1:0] meanOut,
  output logic [SAMPLE_W-1:0] maxDevOut,
  output logic [SAMPLE_W+6:0] devPctOut,
  output logic [7:0]          imbPctOut,
  output logic                darkResult,
  output logic                lineErr,
  output logic                done
);
  ctrlStrobes_t strobes;
  logic cntOk, divDone, frozenDark;

  ustat_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n), .lineEnd(lineEnd), .cntOk(cntOk),
    .divDone(divDone), .frozenDark(frozenDark), .strobes(strobes),
    .done(done), .lineErr(lineErr)
  );

  ustat_datapath #(.SAMPLE_W(SAMPLE_W), .LINE_PIXELS(LINE_PIXELS)) dp_i (
    .clk(clk), .rst_n(rst_n), .pixValid(pixValid), .pixOdd(pixOdd),
    .pixData(pixData), .lineEnd(lineEnd), .darkMode(darkMode),
    .strobes(strobes), .cntOk(cntOk), .divDone(divDone),
    .frozenDark(frozenDark), .meanOut(meanOut), .maxDevOut(maxDevOut),
    .devPctOut(devPctOut), .imbPctOut(imbPctOut), .darkResult(darkResult)
  );
endmodule

// File: rtl/pixel_uniformity_stats_checker.sv
module pixel_uniformity_stats_checker #(
  parameter int SAMPLE_W = 12
) (
  input logic                clk,
  input logic                rst_n,
  input logic [SAMPLE_W-1:0] meanOut,
  input logic [SAMPLE_W-1:0] maxDevOut,
  input logic [SAMPLE_W+6:0] devPctOut,
  input logic [7:0]          imbPctOut,
  input logic                darkResult,
  input logic                lineErr,
  input logic                done
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (!done && !lineErr && meanOut == '0 && maxDevOut == '0));

  assert_imb_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    imbPctOut <= 8'd200);

  assert_dark_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !lineErr && darkResult) |-> (devPctOut == '0 && imbPctOut == '0));

  assert_err_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && lineErr) |-> ($stable(meanOut) && $stable(maxDevOut) &&
                           $stable(devPctOut) && $stable(imbPctOut)));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_hold_between_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(meanOut) && $stable(maxDevOut) && $stable(devPctOut) &&
               $stable(imbPctOut) && $stable(darkResult)));
endmodule

bind pixel_uniformity_stats pixel_uniformity_stats_checker #(.SAMPLE_W(SAMPLE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .meanOut(meanOut), .maxDevOut(maxDevOut),
  .devPctOut(devPctOut), .imbPctOut(imbPctOut), .darkResult(darkResult),
  .lineErr(lineErr), .done(done)
);

// File: tb/pixel_uniformity_stats_tb.sv
module pixel_uniformity_stats_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 12;
  localparam int NPIX = 16;
  localparam int MAXV = (1 << SW) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pixValid = 1'b0, pixOdd = 1'b0, lineEnd = 1'b0, darkMode = 1'b0;
  logic [SW-1:0] pixData = '0;
  logic [SW-1:0] meanOut, maxDevOut;
  logic [SW+6:0] devPctOut;
  logic [7:0] imbPctOut;
  logic darkResult, lineErr, done;

  int checks = 0, fails = 0;
  bit finished = 1'b0;
  int lineBuf[64];
  int eMean = 0, eDev = 0, eDevPct = 0, eImb = 0, eDark = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pixel_uniformity_stats #(.SAMPLE_W(SW), .LINE_PIXELS(NPIX)) dut_i (
    .clk(clk), .rst_n(rst_n), .pixValid(pixValid), .pixOdd(pixOdd),
    .pixData(pixData), .lineEnd(lineEnd), .darkMode(darkMode),
    .meanOut(meanOut), .maxDevOut(maxDevOut), .devPctOut(devPctOut),
    .imbPctOut(imbPctOut), .darkResult(darkResult), .lineErr(lineErr),
    .done(done)
  );

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // expected results of the first n entries of lineBuf, positions 0,2,.. odd-flagged
  function automatic void calcExpected(input int n, input bit dark);
    longint s = 0, p = 0;
    int mn = MAXV, mx = 0, hi, lo;
    for (int i = 0; i < n; i++) begin
      s += lineBuf[i];
      if (lineBuf[i] < mn) mn = lineBuf[i];
      if (lineBuf[i] > mx) mx = lineBuf[i];
      if (i % 2 == 1) p += (lineBuf[i-1] > lineBuf[i]) ? lineBuf[i-1] - lineBuf[i] : lineBuf[i] - lineBuf[i-1];
    end
    eMean = int'(s / NPIX);
    hi = mx - eMean; lo = eMean - mn;
    eDev = (hi > lo) ? hi : lo;
    eDevPct = (dark || eMean == 0) ? 0 : eDev * 100 / eMean;
    eImb = (dark || s == 0) ? 0 : int'(200 * p / s);
    eDark = dark;
  endfunction

  task automatic driveSamples(input int first, input int cnt, input bit gaps);
    for (int i = first; i < first + cnt; i++) begin
      if (gaps && ($urandom % 3 == 0)) begin
        @(negedge clk);
        pixValid = 1'b0; pixData = SW'($urandom); pixOdd = 1'($urandom);
      end
      @(negedge clk);
      pixValid = 1'b1; pixData = SW'(lineBuf[i]); pixOdd = (i % 2 == 0);
    end
    @(negedge clk);
    pixValid = 1'b0;
  endtask

  task automatic endLine(input bit dark, input bit withSample, input int carried);
    @(negedge clk);
    lineEnd = 1'b1; darkMode = dark;
    pixValid = withSample; pixData = SW'(carried); pixOdd = 1'b1;
    @(negedge clk);
    lineEnd = 1'b0; pixValid = 1'b0; darkMode = 1'b0;
  endtask

  task automatic awaitAndCheck(input bit expErr, input string tag);
    int n = 0;
    while (!done && n < 500) begin @(negedge clk); n++; end
    check("R8", {tag, " done seen"}, done, 1);
    check("R7", {tag, " lineErr"}, lineErr, expErr);
    check("R2", {tag, " mean"}, meanOut, eMean);
    check("R3", {tag, " maxDev"}, maxDevOut, eDev);
    check("R4", {tag, " devPct"}, devPctOut, eDevPct);
    check("R5", {tag, " imbPct"}, imbPctOut, eImb);
    check("R6", {tag, " darkResult"}, darkResult, eDark);
    @(negedge clk);
    check("R8", {tag, " done one cycle"}, done, 0);
  endtask

  task automatic runLine(input int n, input bit dark, input bit gaps, input string tag);
    driveSamples(0, n, gaps);
    endLine(dark, 1'b0, 0);
    if (n == NPIX) calcExpected(n, dark);
    awaitAndCheck(n != NPIX, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1", "done in reset", done, 0);
    check("R1", "mean in reset", meanOut, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "lineErr after reset", lineErr, 0);
    check("R1", "devPct after reset", devPctOut, 0);
    check("R1", "darkResult after reset", darkResult, 0);

    for (int i = 0; i < NPIX; i++) lineBuf[i] = 1000;
    runLine(NPIX, 0, 0, "flat");
    for (int i = 0; i < NPIX; i++) lineBuf[i] = 100 + i * 10;
    runLine(NPIX, 0, 1, "ramp");
    for (int i = 0; i < NPIX; i++) lineBuf[i] = (i == 5) ? 3000 : 500;
    runLine(NPIX, 0, 0, "hot pixel");
    for (int i = 0; i < NPIX; i++) lineBuf[i] = 0;
    runLine(NPIX, 0, 1, "zero line");
    for (int i = 0; i < NPIX; i++) lineBuf[i] = MAXV;
    runLine(NPIX, 0, 0, "full scale");
    for (int i = 0; i < NPIX; i++) lineBuf[i] = (i % 2 == 0) ? 400 : 0;
    runLine(NPIX, 0, 0, "full imbalance");
    for (int i = 0; i < NPIX; i++) lineBuf[i] = 20 + int'($urandom % 30);
    runLine(NPIX, 1, 1, "dark R6");

    // R7: short and long lines keep previous results
    runLine(NPIX - 1, 0, 0, "short R7");
    for (int i = 0; i < NPIX + 1; i++) lineBuf[i] = 77;
    runLine(NPIX + 1, 0, 1, "long R7");
    for (int i = 0; i < NPIX; i++) lineBuf[i] = 600 + int'($urandom % 200);
    runLine(NPIX, 0, 0, "recover R7");

    // R9: sample in the end-of-line cycle opens the next line
    for (int i = 0; i < NPIX; i++) lineBuf[i] = 300 + int'($urandom % 100);
    driveSamples(0, NPIX, 0);
    endLine(0, 1'b1, 3500);
    calcExpected(NPIX, 0);
    awaitAndCheck(0, "carry first R9");
    lineBuf[0] = 3500;
    for (int i = 1; i < NPIX; i++) lineBuf[i] = 300 + int'($urandom % 100);
    driveSamples(1, NPIX - 1, 0);
    endLine(0, 1'b0, 0);
    calcExpected(NPIX, 0);
    awaitAndCheck(0, "carry second R9");

    for (int k = 0; k < 20; k++) begin
      int base = int'($urandom % 3000);
      int spread = 1 + int'($urandom % 1000);
      for (int i = 0; i < NPIX; i++) lineBuf[i] = base + int'($urandom % spread);
      runLine(NPIX, k % 5 == 4, 1, "random");
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule